// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word for one port of an Ethernet PHY. A register access unit writes it with a one-cycle write strobe and reads it through a read bus that always shows the current contents. On reset the speed code and the auto-negotiation enable are loaded from strap inputs. The duplex field resets to full duplex, and every other writable field resets to 0. The block drives the PHY core with level controls (loopback, isolate, power-down, collision test) and with one-cycle action pulses (soft reset, auto-negotiation restart). It also drives an effective speed and duplex that come either from the manual fields or from the auto-negotiation result.

Releasing power-down starts a timed internal reset. A three-state machine tracks this. ST_IDLE is normal operation. It moves to ST_PWRDN when an accepted write sets the power-down field. ST_PWRDN moves to ST_WAKE when an accepted write clears that field. ST_WAKE counts `CLK_KHZ*LOCK_MS` clock cycles, which is at least the required 1 ms at the stated clock rate, and then returns to ST_IDLE. While in ST_WAKE, the block raises busy, discards writes and returns zero on reads. The reset is synchronous and active low.

Top module: `phy_ctl_reg`

## Requirements
- R1: While reset is low, the read bus shows bit 6 = strap speed MSB, bit 13 = strap speed LSB, bit 12 = strap auto-negotiation enable, bit 8 = 1, and all other bits 0. The effective speed is 00, effective full duplex is 1, and all pulses, level outputs and busy are 0.
- R2: An accepted write with bit 15 = 1 sets bit 15 for exactly one cycle after the write edge, and the soft reset pulse is high during that same cycle. A second such write while bit 15 still reads 1 does not extend the pulse. Bit 15 never alters the other fields.
- R3: An accepted write with bit 9 = 1 behaves in the same way, but for bit 9 and the auto-negotiation restart pulse.
- R4: The manual speed code is {bit 6, bit 13}: 10 = 1000 Mb/s, 01 = 100 Mb/s, 00 = 10 Mb/s. When bit 12 is 0, the effective speed takes a valid manual code one cycle after the register holds it.
- R5: When bit 12 is 0 and the manual code is the reserved 11, the effective speed keeps its previous value.
- R6: When bit 12 is 1, the effective speed and duplex follow the auto-negotiation result inputs one cycle later, and the manual speed and duplex bits have no effect on them.
- R7: When bit 12 is 0, effective full duplex follows bit 8 (1 = full) one cycle later.
- R8: Bits 14, 10, 7 and 11 drive the loopback, isolate, collision test and power-down outputs directly from the stored value.
- R9: Bits 5:0 always read 0, and data written to them is discarded.
- R10: An accepted write that changes bit 11 from 1 to 0 raises busy from the next cycle for exactly CLK_KHZ*LOCK_MS cycles.
- R11: While busy is high, writes are ignored and the read bus returns 0.
- R12: The core reset output is high whenever the soft reset pulse or busy is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_speed | input | 2 | Reset value of the manual speed code {MSB, LSB} |
| strap_an_en | input | 1 | Reset value of the auto-negotiation enable |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| an_speed | input | 2 | Speed code resolved by auto-negotiation |
| an_full_dup | input | 1 | Duplex resolved by auto-negotiation |
| rd_data | output | 16 | Current register contents (0 while busy) |
| soft_rst_pulse | output | 1 | One-cycle soft reset action |
| an_restart_pulse | output | 1 | One-cycle auto-negotiation restart action |
| loopback | output | 1 | Local loopback enable |
| isolate | output | 1 | Logical isolation from the switch core |
| power_down | output | 1 | Power-down request |
| col_test | output | 1 | Collision test enable |
| eff_speed | output | 2 | Effective speed code |
| eff_full_dup | output | 1 | Effective duplex, 1 = full |
| busy | output | 1 | Lockout after power-down release |
| core_rst | output | 1 | Reset request to the PHY core |

## Verification
The hardest situation to reach is a write that lands inside the lockout window, because it needs a power-down set, then a release, then traffic arriving within a short count. The bench shortens the lockout to 20 cycles through the clock-rate parameter. It biases the random power-down bit so that set and release happen often, and it keeps the write strobe busy during the window. A directed sequence also writes during lockout on purpose and checks that the contents are unchanged once the window ends. The reserved speed hold is reached by steering random writes toward auto-negotiation disabled and speed 11, and by a directed write of 11 after a known valid code.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int REG_W   = 16;
    localparam int SPD_W   = 2;

    localparam int P_SRST  = 15;
    localparam int P_LOOP  = 14;
    localparam int P_SLSB  = 13;
    localparam int P_ANEN  = 12;
    localparam int P_PWDN  = 11;
    localparam int P_ISO   = 10;
    localparam int P_ANRS  = 9;
    localparam int P_DUP   = 8;
    localparam int P_COL   = 7;
    localparam int P_SMSB  = 6;
    localparam int RESV_W  = 6;

    localparam logic [SPD_W-1:0] SPD_RESV = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PWRDN = 2'd1,
        ST_WAKE  = 2'd2
    } wake_state_t;

    typedef struct packed {
        logic loopback;
        logic spd_lsb;
        logic an_en;
        logic pwrdn;
        logic isolate;
        logic full_dup;
        logic col_test;
        logic spd_msb;
    } ctl_fields_t;

endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
    import phy_ctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SPD_W-1:0]        strap_speed,
    input  logic                    strap_an_en,
    input  logic                    wr_en,
    input  logic [REG_W-1:RESV_W]   wr_hi,
    input  logic                    busy,
    output ctl_fields_t             fld,
    output logic                    pd_nxt,
    output logic                    srst_q,
    output logic                    anrs_q
);

    logic        accept;
    ctl_fields_t fld_nxt;

    assign accept = wr_en && !busy;

    always_comb begin
        fld_nxt = fld;
        if (accept) begin
            fld_nxt.loopback = wr_hi[P_LOOP];
            fld_nxt.spd_lsb  = wr_hi[P_SLSB];
            fld_nxt.an_en    = wr_hi[P_ANEN];
            fld_nxt.pwrdn    = wr_hi[P_PWDN];
            fld_nxt.isolate  = wr_hi[P_ISO];
            fld_nxt.full_dup = wr_hi[P_DUP];
            fld_nxt.col_test = wr_hi[P_COL];
            fld_nxt.spd_msb  = wr_hi[P_SMSB];
        end
    end

    assign pd_nxt = fld_nxt.pwrdn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld.loopback <= 1'b0;
            fld.spd_lsb  <= strap_speed[0];
            fld.an_en    <= strap_an_en;
            fld.pwrdn    <= 1'b0;
            fld.isolate  <= 1'b0;
            fld.full_dup <= 1'b1;
            fld.col_test <= 1'b0;
            fld.spd_msb  <= strap_speed[1];
            srst_q       <= 1'b0;
            anrs_q       <= 1'b0;
        end else begin
            fld    <= fld_nxt;
            srst_q <= accept && wr_hi[P_SRST] && !srst_q;
            anrs_q <= accept && wr_hi[P_ANRS] && !anrs_q;
        end
    end

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q); // R2
    AST_ANRS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        anrs_q |=> !anrs_q); // R3
    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fld)); // R11

endmodule

// File: rtl/phy_ctl_mode.sv
module phy_ctl_mode
    import phy_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              an_en,
    input  logic [SPD_W-1:0]  man_speed,
    input  logic              man_dup,
    input  logic [SPD_W-1:0]  an_speed,
    input  logic              an_dup,
    output logic [SPD_W-1:0]  eff_speed,
    output logic              eff_dup
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_speed <= '0;
            eff_dup   <= 1'b1;
        end else if (an_en) begin
            eff_speed <= an_speed;
            eff_dup   <= an_dup;
        end else begin
            if (man_speed != SPD_RESV)
                eff_speed <= man_speed;
            eff_dup <= man_dup;
        end
    end

    AST_RESV_HOLDS_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (!an_en && man_speed == SPD_RESV) |=> $stable(eff_speed)); // R5
    AST_AN_DRIVES_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        an_en |=> (eff_speed == $past(an_speed) && eff_dup == $past(an_dup))); // R6
    AST_NEVER_RESV_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!an_en && man_speed != SPD_RESV) |=> eff_speed != SPD_RESV); // R4

endmodule

// File: rtl/phy_ctl_wake.sv
module phy_ctl_wake
    import phy_ctl_pkg::*;
#(
    parameter int LOCK_CYC = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pd_q,
    input  logic        pd_nxt,
    output logic        busy
);

    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

    wake_state_t state, state_nxt;
    logic [CW-1:0] cnt;
    logic          cnt_done;

    assign cnt_done = (cnt == LAST);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (pd_nxt)   state_nxt = ST_PWRDN;
            ST_PWRDN: if (!pd_nxt)  state_nxt = ST_WAKE;
            ST_WAKE:  if (cnt_done) state_nxt = ST_IDLE;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= (state == ST_WAKE && !cnt_done) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        busy = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_PWRDN: busy = 1'b0;
            ST_WAKE:  busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    AST_PWRDN_TRACKS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRDN) == pd_q); // R8
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R10

endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
    import phy_ctl_pkg::*;
#(
    parameter int CLK_KHZ = 125000,
    parameter int LOCK_MS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap_speed,
    input  logic        strap_an_en,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [1:0]  an_speed,
    input  logic        an_full_dup,
    output logic [15:0] rd_data,
    output logic        soft_rst_pulse,
    output logic        an_restart_pulse,
    output logic        loopback,
    output logic        isolate,
    output logic        power_down,
    output logic        col_test,
    output logic [1:0]  eff_speed,
    output logic        eff_full_dup,
    output logic        busy,
    output logic        core_rst
);

    localparam int LOCK_CYC = CLK_KHZ * LOCK_MS;

    ctl_fields_t fld;
    logic        pd_nxt;
    logic        srst_q, anrs_q;
    logic [REG_W-1:0] image;
    logic        unused_wr_low;

    assign unused_wr_low = ^wr_data[RESV_W-1:0];

    phy_ctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_speed (strap_speed),
        .strap_an_en (strap_an_en),
        .wr_en       (wr_en),
        .wr_hi       (wr_data[REG_W-1:RESV_W]),
        .busy        (busy),
        .fld         (fld),
        .pd_nxt      (pd_nxt),
        .srst_q      (srst_q),
        .anrs_q      (anrs_q)
    );

    phy_ctl_wake #(.LOCK_CYC(LOCK_CYC)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_q   (fld.pwrdn),
        .pd_nxt (pd_nxt),
        .busy   (busy)
    );

    phy_ctl_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .an_en     (fld.an_en),
        .man_speed ({fld.spd_msb, fld.spd_lsb}),
        .man_dup   (fld.full_dup),
        .an_speed  (an_speed),
        .an_dup    (an_full_dup),
        .eff_speed (eff_speed),
        .eff_dup   (eff_full_dup)
    );

    always_comb begin
        image         = '0;
        image[P_SRST] = srst_q;
        image[P_LOOP] = fld.loopback;
        image[P_SLSB] = fld.spd_lsb;
        image[P_ANEN] = fld.an_en;
        image[P_PWDN] = fld.pwrdn;
        image[P_ISO]  = fld.isolate;
        image[P_ANRS] = anrs_q;
        image[P_DUP]  = fld.full_dup;
        image[P_COL]  = fld.col_test;
        image[P_SMSB] = fld.spd_msb;
    end

    assign rd_data          = busy ? '0 : image;
    assign soft_rst_pulse   = srst_q;
    assign an_restart_pulse = anrs_q;
    assign loopback         = fld.loopback;
    assign isolate          = fld.isolate;
    assign power_down       = fld.pwrdn;
    assign col_test         = fld.col_test;
    assign core_rst         = srst_q | busy;

    AST_RELEASE_STARTS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_down) |-> busy); // R10
    AST_RESV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RESV_W-1:0] == '0); // R9
    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data == '0); // R11
    AST_NO_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> !soft_rst_pulse); // R12

endmodule

// File: tb/sim_phy_ctl_reg.sv
`timescale 1ns/1ps
module sim_phy_ctl_reg;

    localparam int KHZ  = 10;
    localparam int MS   = 2;
    localparam int LOCK = KHZ * MS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_speed = 2'b10;
    logic        strap_an_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  an_speed = 2'b00;
    logic        an_full_dup = 1'b0;
    logic [15:0] rd_data;
    logic        soft_rst_pulse, an_restart_pulse, loopback, isolate;
    logic        power_down, col_test, eff_full_dup, busy, core_rst;
    logic [1:0]  eff_speed;

    always #5 clk = ~clk;

    phy_ctl_reg #(.CLK_KHZ(KHZ), .LOCK_MS(MS)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic m_lb, m_sl, m_an, m_pd, m_iso, m_dup, m_col, m_sm, m_srst, m_anrs;
    logic [1:0] m_espd;
    logic       m_edup;
    int         m_busy;

    function automatic logic [15:0] m_img();
        logic [15:0] v = '0;
        v[15] = m_srst; v[14] = m_lb; v[13] = m_sl; v[12] = m_an;
        v[11] = m_pd;   v[10] = m_iso; v[9] = m_anrs; v[8] = m_dup;
        v[7]  = m_col;  v[6]  = m_sm;
        return (m_busy > 0) ? 16'h0000 : v;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9 R11 rd_data", rd_data, m_img());
        chk("R2 soft_rst_pulse", {15'd0, soft_rst_pulse}, {15'd0, m_srst});
        chk("R3 an_restart_pulse", {15'd0, an_restart_pulse}, {15'd0, m_anrs});
        chk("R8 levels", {12'd0, loopback, isolate, power_down, col_test},
                         {12'd0, m_lb, m_iso, m_pd, m_col});
        chk("R4 R5 R6 eff_speed", {14'd0, eff_speed}, {14'd0, m_espd});
        chk("R6 R7 eff_full_dup", {15'd0, eff_full_dup}, {15'd0, m_edup});
        chk("R10 busy", {15'd0, busy}, {15'd0, logic'(m_busy > 0)});
        chk("R12 core_rst", {15'd0, core_rst}, {15'd0, logic'(m_srst || m_busy > 0)});
    endtask

    task automatic model_reset();
        m_lb = 0; m_sl = strap_speed[0]; m_an = strap_an_en; m_pd = 0; m_iso = 0;
        m_dup = 1; m_col = 0; m_sm = strap_speed[1]; m_srst = 0; m_anrs = 0;
        m_espd = 2'b00; m_edup = 1; m_busy = 0;
    endtask

    // R1: reset with the given straps, check while reset is held
    task automatic do_reset(logic [1:0] sp, logic an);
        rst_n = 0; wr_en = 0; strap_speed = sp; strap_an_en = an;
        repeat (2) @(negedge clk);
        model_reset();
        chk("R1 reset rd_data", rd_data, {2'b00, sp[0], an, 3'b000, 1'b1, 1'b0, sp[1], 6'd0});
        compare_all();
        rst_n = 1;
    endtask

    // one clock: drive, predict, advance, compare
    task automatic cyc(logic we, logic [15:0] d, logic [1:0] asp, logic adup);
        logic acc;
        logic n_srst, n_anrs;
        logic [1:0] n_espd;
        logic n_edup;
        int   n_busy;
        wr_en = we; wr_data = d; an_speed = asp; an_full_dup = adup;
        acc    = we && (m_busy == 0);
        n_srst = acc && d[15] && !m_srst;
        n_anrs = acc && d[9] && !m_anrs;
        n_busy = (m_busy > 0) ? m_busy - 1 : 0;
        if (acc && m_pd && !d[11]) n_busy = LOCK;
        if (m_an) begin
            n_espd = asp; n_edup = adup;
        end else begin
            n_espd = ({m_sm, m_sl} != 2'b11) ? {m_sm, m_sl} : m_espd;
            n_edup = m_dup;
        end
        @(negedge clk);
        if (acc) begin
            m_lb = d[14]; m_sl = d[13]; m_an = d[12]; m_pd = d[11];
            m_iso = d[10]; m_dup = d[8]; m_col = d[7]; m_sm = d[6];
        end
        m_srst = n_srst; m_anrs = n_anrs; m_busy = n_busy;
        m_espd = n_espd; m_edup = n_edup;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0011));
        @(negedge clk);
        do_reset(2'b10, 1'b0);
        cyc(0, 16'h0000, 2'b00, 0);
        chk("R4 strap 1000 code", {14'd0, eff_speed}, 16'd2);

        // R5: reserved manual code holds 1000
        cyc(1, 16'h2040, 2'b01, 0);
        cyc(0, 16'h0000, 2'b01, 0);
        cyc(0, 16'h0000, 2'b01, 0);
        chk("R5 hold after reserved", {14'd0, eff_speed}, 16'd2);
        // R4: 100 Mb/s, half duplex
        cyc(1, 16'h2000, 2'b10, 1);
        cyc(0, 16'h0000, 2'b10, 1);
        chk("R4 R7 manual 100 half", {13'd0, eff_speed, eff_full_dup}, 16'b010);
        // R9: reserved low bits written with ones
        cyc(1, 16'h003F, 2'b00, 0);
        chk("R9 low bits discarded", rd_data, 16'h0000);
        // R2: back-to-back soft reset writes give a single pulse
        cyc(1, 16'h8000 | 16'h4000, 2'b00, 0);
        chk("R2 pulse high", {15'd0, soft_rst_pulse}, 16'd1);
        cyc(1, 16'hC000, 2'b00, 0);
        chk("R2 pulse cleared", {15'd0, soft_rst_pulse}, 16'd0);
        // R3: restart pulse
        cyc(1, 16'h0200, 2'b00, 0);
        chk("R3 restart pulse", {15'd0, an_restart_pulse}, 16'd1);
        cyc(0, 16'h0000, 2'b00, 0);
        // R6: auto-negotiation overrides manual bits
        cyc(1, 16'h1000, 2'b10, 1);
        cyc(0, 16'h0000, 2'b10, 1);
        chk("R6 an follows", {13'd0, eff_speed, eff_full_dup}, 16'b101);
        // R10 R11: power-down, release, write during lockout
        cyc(1, 16'h0800, 2'b00, 0);
        cyc(1, 16'h0400, 2'b00, 0);
        chk("R10 busy after release", {15'd0, busy}, 16'd1);
        cyc(1, 16'h4480, 2'b00, 0);
        chk("R11 read zero in lockout", rd_data, 16'h0000);
        for (int i = 0; i < LOCK; i++) cyc(0, 16'h0000, 2'b00, 0);
        chk("R11 write ignored", rd_data, 16'h0400);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            d[12] = ($urandom % 4) == 0;
            d[11] = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) {d[6], d[13]} = 2'b11;
            cyc(($urandom % 2) == 0, d, 2'($urandom), 1'($urandom));
        end

        do_reset(2'b01, 1'b1);
        cyc(0, 16'h0000, 2'b11, 0);
        chk("R1 R6 strap an enable", {14'd0, eff_speed}, 16'd3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule